// File: doc/BRIEF.md
# Flash Completion Polling Controller

This block runs on the host side of a parallel flash and decides when a program or erase operation has finished inside the device. The command sequence is written elsewhere. Once its last write has landed (the fourth write for a program, the sixth for an erase), the host raises `start_i`. It supplies the address to poll, the data it expects to find, and whether the operation was an erase. The controller then issues a stream of single reads over a simple request/response port, toward a bus adapter, and inspects the status bits that come back.

Two detection methods are available, selected per operation. In data-polling mode the controller watches bit 7. While the device is busy, bit 7 reads as the complement of the expected value. Bit 7 can become valid before the lower bits do, so a match is always confirmed with one more read. In toggle mode the controller watches bit 6, which flips on every read while the device is busy. Two consecutive reads with the same bit 6 mean the device has stopped, and one more read then fetches the settled word. In both modes the settled word decides pass or fail. A read budget turns a device that never finishes into a fail.

For an erase, the poll address must lie in a sector that is being erased, not in a protected sector. Choosing that address is up to the host.

Top module: `flash_poll_ctrl`

## Requirements
- R1: After reset, `rd_req_o`, `done_o`, `pass_o` and `fail_o` are all low, and no read is requested until `start_i` is seen.
- R2: Every read request is a one-cycle pulse on `rd_req_o`, carrying the address captured at start on `rd_addr_o`. A new request is never issued while a previous one has not yet been answered by `rd_valid_i`.
- R3: With `mode_i`=0 (data polling), a polling read completes the wait when its bit 7 equals bit 7 of the expected word. With `erase_i`=1, the expected word is all ones whatever `expect_i` holds, so bit 7 must read 1.
- R4: In data polling, a bit 7 match is never final. Exactly one further read follows, and the result is pass only when that read equals the expected word in every bit.
- R5: With `mode_i`=1 (toggle), the first polling read is only stored. A later polling read completes the wait when its bit 6 equals bit 6 of the read just before it. Exactly one further read then follows, and a full-word compare against the expected word gives pass or fail.
- R6: At most `MAX_POLLS` polling reads are issued per operation. If the last allowed one does not complete the wait, the operation ends with fail and no confirming read. A completion seen on that last read still leads to the confirming read.
- R7: `done_o` is a one-cycle pulse, raised in the cycle after the deciding response. Exactly one of `pass_o` and `fail_o` is high from that cycle on, and both stay unchanged until the next accepted start, which clears them one cycle later.
- R8: A `start_i` pulse arriving while an operation is in progress is ignored: the running operation keeps its address, expected word and mode, and its outcome is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin polling (accepted only when idle) |
| mode_i | input | 1 | 0 = bit-7 data polling, 1 = bit-6 toggle detection |
| erase_i | input | 1 | 1 = erase operation, expected word forced to all ones |
| addr_i | input | AW | Address to poll |
| expect_i | input | DW | Expected final data for a program |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | AW | Address of the requested read |
| rd_valid_i | input | 1 | Read response strobe |
| rd_data_i | input | DW | Read response data |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Held result: operation succeeded |
| fail_o | output | 1 | Held result: mismatch or budget exhausted |

## Verification
Two decisions can fall on the same response: a read that completes the wait (a bit 7 match, or a stable bit 6) may also be the last read the budget allows. The bench provokes this by making the device model finish exactly on read `MAX_POLLS`, in both modes. It also makes the model finish one read too late. The first case must yield a confirming read and pass, the second must yield fail with exactly `MAX_POLLS` reads. Both are judged by counting requests and checking the held result.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } fpc_state_e;

   typedef enum logic {
      PH_POLL    = 1'b0,
      PH_CONFIRM = 1'b1
   } fpc_phase_e;

   typedef enum logic {
      MODE_DATA   = 1'b0,
      MODE_TOGGLE = 1'b1
   } fpc_mode_e;

endpackage

// File: rtl/fpc_budget.sv
module fpc_budget #(
   parameter int MAX_POLLS = 1024,
   localparam int CW = $clog2(MAX_POLLS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic step_i,
   output logic spent_o
);

   logic [CW-1:0] used_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         used_q <= '0;
      else if (clear_i)
         used_q <= '0;
      else if (step_i && (used_q != CW'(MAX_POLLS)))
         used_q <= used_q + 1'b1;
   end

   assign spent_o = (used_q >= CW'(MAX_POLLS));

endmodule

// File: rtl/fpc_status_eval.sv
module fpc_status_eval #(
   parameter int DW         = 16,
   parameter int FLAG_BIT   = 7,
   parameter int TOGGLE_BIT = 6
) (
   input  logic [DW-1:0] rd_data_i,
   input  logic [DW-1:0] prev_i,
   input  logic [DW-1:0] expect_i,
   output logic          flag_match_o,
   output logic          toggle_still_o,
   output logic          word_match_o
);

   logic [DW-1:0] bit_diff;

   for (genvar b = 0; b < DW; b++) begin : g_bit
      assign bit_diff[b] = rd_data_i[b] ^ expect_i[b];
   end

   assign flag_match_o   = ~bit_diff[FLAG_BIT];
   assign toggle_still_o = (rd_data_i[TOGGLE_BIT] == prev_i[TOGGLE_BIT]);
   assign word_match_o   = ~|bit_diff;

endmodule

// File: rtl/fpc_sequencer.sv
module fpc_sequencer
   import fpc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic mode_i,
   input  logic rd_valid_i,
   input  logic flag_match_i,
   input  logic toggle_still_i,
   input  logic word_match_i,
   input  logic spent_i,
   output logic rd_req_o,
   output logic capture_o,
   output logic prev_en_o,
   output logic budget_clear_o,
   output logic budget_step_o,
   output logic done_o,
   output logic pass_o,
   output logic fail_o
);

   fpc_state_e state_q;
   fpc_phase_e phase_q;
   fpc_mode_e  mode_q;
   logic       first_q;
   logic       idle_start;
   logic       poll_resp;
   logic       confirm_resp;
   logic       complete;

   assign idle_start   = (state_q == ST_IDLE) && start_i;
   assign poll_resp    = (state_q == ST_WAIT) && rd_valid_i && (phase_q == PH_POLL);
   assign confirm_resp = (state_q == ST_WAIT) && rd_valid_i && (phase_q == PH_CONFIRM);
   assign complete     = (mode_q == MODE_DATA) ? flag_match_i : (!first_q && toggle_still_i);

   assign rd_req_o       = (state_q == ST_ISSUE);
   assign capture_o      = idle_start;
   assign budget_clear_o = idle_start;
   assign budget_step_o  = (state_q == ST_ISSUE) && (phase_q == PH_POLL);
   assign prev_en_o      = poll_resp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         phase_q <= PH_POLL;
         mode_q  <= MODE_DATA;
         first_q <= 1'b1;
         done_o  <= 1'b0;
         pass_o  <= 1'b0;
         fail_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  mode_q  <= fpc_mode_e'(mode_i);
                  phase_q <= PH_POLL;
                  first_q <= 1'b1;
                  pass_o  <= 1'b0;
                  fail_o  <= 1'b0;
                  state_q <= ST_ISSUE;
               end
            end
            ST_ISSUE: state_q <= ST_WAIT;
            ST_WAIT: begin
               if (confirm_resp) begin
                  done_o  <= 1'b1;
                  pass_o  <= word_match_i;
                  fail_o  <= ~word_match_i;
                  state_q <= ST_IDLE;
               end else if (poll_resp) begin
                  first_q <= 1'b0;
                  if (complete) begin
                     phase_q <= PH_CONFIRM;
                     state_q <= ST_ISSUE;
                  end else if (spent_i) begin
                     done_o  <= 1'b1;
                     fail_o  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     state_q <= ST_ISSUE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl #(
   parameter int DW         = 16,
   parameter int AW         = 24,
   parameter int MAX_POLLS  = 1024,
   parameter int FLAG_BIT   = 7,
   parameter int TOGGLE_BIT = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          mode_i,
   input  logic          erase_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] expect_i,
   output logic          rd_req_o,
   output logic [AW-1:0] rd_addr_o,
   input  logic          rd_valid_i,
   input  logic [DW-1:0] rd_data_i,
   output logic          done_o,
   output logic          pass_o,
   output logic          fail_o
);

   if (DW < 8) begin : g_bad_dw
      $error("flash_poll_ctrl: DW must be at least 8");
   end
   if (FLAG_BIT >= DW || TOGGLE_BIT >= DW || FLAG_BIT == TOGGLE_BIT) begin : g_bad_bits
      $error("flash_poll_ctrl: status bit positions invalid");
   end
   if (MAX_POLLS < 2) begin : g_bad_polls
      $error("flash_poll_ctrl: MAX_POLLS must be at least 2");
   end

   logic [AW-1:0] addr_q;
   logic [DW-1:0] expect_q;
   logic [DW-1:0] prev_q;
   logic          capture;
   logic          prev_en;
   logic          budget_clear;
   logic          budget_step;
   logic          spent;
   logic          flag_match;
   logic          toggle_still;
   logic          word_match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         expect_q <= '0;
         prev_q   <= '0;
      end else begin
         if (capture) begin
            addr_q   <= addr_i;
            expect_q <= erase_i ? '1 : expect_i;
         end
         if (prev_en)
            prev_q <= rd_data_i;
      end
   end

   assign rd_addr_o = addr_q;

   fpc_status_eval #(
      .DW(DW), .FLAG_BIT(FLAG_BIT), .TOGGLE_BIT(TOGGLE_BIT)
   ) u_eval (
      .rd_data_i     (rd_data_i),
      .prev_i        (prev_q),
      .expect_i      (expect_q),
      .flag_match_o  (flag_match),
      .toggle_still_o(toggle_still),
      .word_match_o  (word_match)
   );

   fpc_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear_i(budget_clear),
      .step_i (budget_step),
      .spent_o(spent)
   );

   fpc_sequencer u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .mode_i        (mode_i),
      .rd_valid_i    (rd_valid_i),
      .flag_match_i  (flag_match),
      .toggle_still_i(toggle_still),
      .word_match_i  (word_match),
      .spent_i       (spent),
      .rd_req_o      (rd_req_o),
      .capture_o     (capture),
      .prev_en_o     (prev_en),
      .budget_clear_o(budget_clear),
      .budget_step_o (budget_step),
      .done_o        (done_o),
      .pass_o        (pass_o),
      .fail_o        (fail_o)
   );

endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
   parameter int MAX_POLLS = 1024
) (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic rd_req_o,
   input logic rd_valid_i,
   input logic done_o,
   input logic pass_o,
   input logic fail_o
);

   logic out_q;
   int   reads_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q   <= 1'b0;
         reads_q <= 0;
      end else begin
         if (rd_req_o)
            out_q <= 1'b1;
         else if (rd_valid_i)
            out_q <= 1'b0;
         if (done_o)
            reads_q <= 0;
         else if (rd_req_o)
            reads_q <= reads_q + 1;
      end
   end

   assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |=> !rd_req_o);

   assert_one_outstanding_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> !out_q);

   assert_read_budget_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> (reads_q <= MAX_POLLS));

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (pass_o ^ fail_o));

   assert_result_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(pass_o && fail_o));

   assert_pass_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pass_o) |-> done_o);

   assert_fail_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fail_o) |-> $past(start_i));

endmodule

bind flash_poll_ctrl fpc_checker #(.MAX_POLLS(MAX_POLLS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .rd_req_o  (rd_req_o),
   .rd_valid_i(rd_valid_i),
   .done_o    (done_o),
   .pass_o    (pass_o),
   .fail_o    (fail_o)
);

// File: tb/flash_poll_ctrl_tb.sv
module flash_poll_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int DW  = 16;
   localparam int AW  = 20;
   localparam int MAXP = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          mode_i = 1'b0;
   logic          erase_i = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic [DW-1:0] expect_i = '0;
   logic          rd_req_o;
   logic [AW-1:0] rd_addr_o;
   logic          rd_valid_i;
   logic [DW-1:0] rd_data_i;
   logic          done_o, pass_o, fail_o;

   int n_tests = 0;
   int n_fail  = 0;

   // device model state
   bit            m_mode;
   int            m_busy;
   logic [DW-1:0] m_final;
   logic [DW-1:0] m_exp;
   logic [DW-1:0] m_salt;
   bit            m_garble;
   int            rd_idx;
   int            addr_err;
   logic [AW-1:0] cur_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_poll_ctrl #(.DW(DW), .AW(AW), .MAX_POLLS(MAXP)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .erase_i(erase_i), .addr_i(addr_i), .expect_i(expect_i),
      .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
      .rd_data_i(rd_data_i), .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o)
   );

   function automatic logic [DW-1:0] model_read(int i);
      logic [DW-1:0] w;
      w = m_salt ^ DW'(i * 937);
      if (m_mode == 1'b0) begin
         if (i <= m_busy) w[7] = ~m_exp[7];
         else if (i == m_busy + 1 && m_garble) w = m_final ^ DW'(16'h0055);
         else w = m_final;
      end else begin
         if (i <= m_busy) w[6] = i[0];
         else w = m_final;
      end
      return w;
   endfunction

   // reference outcome of the polling procedure from the requirements
   function automatic void ref_run(output int reads, output bit ok);
      logic [DW-1:0] prev, v;
      reads = 0; ok = 1'b0;
      prev = '0;
      for (int k = 1; k <= MAXP; k++) begin
         v = model_read(k);
         if ((m_mode == 1'b0 && v[7] == m_exp[7]) ||
             (m_mode == 1'b1 && k >= 2 && v[6] == prev[6])) begin
            reads = k + 1;
            ok = (model_read(k + 1) == m_exp);
            return;
         end
         prev = v;
      end
      reads = MAXP;
      ok = 1'b0;
   endfunction

   task automatic check(bit cond, string req, int act, int exp);
      n_tests++;
      if (!cond) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // read responder
   initial begin
      rd_valid_i = 1'b0;
      rd_data_i  = '0;
      forever begin
         @(negedge clk);
         while (rd_req_o === 1'b1) begin
            rd_idx++;
            if (rd_addr_o !== cur_addr) addr_err++;
            repeat (1 + $urandom % 3) @(negedge clk);
            rd_valid_i = 1'b1;
            rd_data_i  = model_read(rd_idx);
            @(negedge clk);
            rd_valid_i = 1'b0;
            rd_data_i  = '0;
         end
      end
   end

   task automatic run_op(bit mode, bit erase, logic [DW-1:0] exp_in, int busy,
                         logic [DW-1:0] fin, bit garble, bit poke, string tag);
      int  exp_reads;
      bit  exp_ok;
      bit  got;
      m_mode   = mode;
      m_busy   = busy;
      m_exp    = erase ? '1 : exp_in;
      m_final  = fin;
      m_garble = garble;
      m_salt   = DW'($urandom);
      rd_idx   = 0;
      addr_err = 0;
      cur_addr = AW'($urandom);
      ref_run(exp_reads, exp_ok);
      @(negedge clk);
      mode_i = mode; erase_i = erase; expect_i = exp_in; addr_i = cur_addr;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      addr_i = ~cur_addr; expect_i = ~exp_in; mode_i = ~mode; erase_i = ~erase;
      check(!pass_o && !fail_o, {tag, " R7 start clears result"}, {pass_o, fail_o}, 0);
      got = 1'b0;
      for (int c = 0; c < 4000; c++) begin
         if (done_o) begin got = 1'b1; break; end
         if (poke && c == 3) start_i = 1'b1;
         if (poke && c == 4) start_i = 1'b0;
         @(negedge clk);
      end
      start_i = 1'b0;
      check(got, {tag, " R7 done seen"}, got, 1);
      check(pass_o == exp_ok && fail_o == !exp_ok,
            {tag, poke ? " R8 R4 R5 R6 result" : " R3 R4 R5 R6 result"}, pass_o, exp_ok);
      check(rd_idx == exp_reads, {tag, " R6 read count"}, rd_idx, exp_reads);
      check(addr_err == 0, {tag, " R2 read address"}, addr_err, 0);
      @(negedge clk);
      check(!done_o, {tag, " R7 done one cycle"}, done_o, 0);
      repeat (3) @(negedge clk);
      check(pass_o == exp_ok && fail_o == !exp_ok, {tag, " R7 result held"}, pass_o, exp_ok);
      check(!rd_req_o && rd_idx == exp_reads, {tag, " R1 no read while idle"}, rd_idx, exp_reads);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      check(!rd_req_o && !done_o && !pass_o && !fail_o, "R1 reset outputs", {rd_req_o, done_o, pass_o, fail_o}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(!rd_req_o && !done_o && !pass_o && !fail_o, "R1 idle after reset", {rd_req_o, done_o, pass_o, fail_o}, 0);

      // R3/R4 data polling, program, low bits invalid on first match
      run_op(1'b0, 1'b0, 16'h1234, 3, 16'h1234, 1'b1, 1'b0, "data_prog_garble");
      // R3 erase forces all-ones expectation
      run_op(1'b0, 1'b1, 16'h0F0F, 4, 16'hFFFF, 1'b0, 1'b0, "data_erase");
      // R4 confirming read mismatches
      run_op(1'b0, 1'b0, 16'h00A5, 2, 16'h01A5, 1'b0, 1'b0, "data_mismatch");
      // R6 completion on the last allowed read, and one read too late
      run_op(1'b0, 1'b0, 16'h8081, MAXP - 1, 16'h8081, 1'b1, 1'b0, "data_edge_last");
      run_op(1'b0, 1'b0, 16'h8081, MAXP, 16'h8081, 1'b0, 1'b0, "data_timeout");
      // R5 toggle mode
      run_op(1'b1, 1'b0, 16'h4321, 5, 16'h4321, 1'b0, 1'b0, "tog_prog");
      run_op(1'b1, 1'b0, 16'h4321, 0, 16'h4321, 1'b0, 1'b0, "tog_immediate");
      run_op(1'b1, 1'b0, 16'h7777, 3, 16'h7767, 1'b0, 1'b0, "tog_mismatch");
      run_op(1'b1, 1'b1, 16'h0000, 6, 16'hFFFF, 1'b0, 1'b0, "tog_erase");
      run_op(1'b1, 1'b0, 16'h5555, 40, 16'h5555, 1'b0, 1'b0, "tog_timeout");
      run_op(1'b1, 1'b0, 16'h2BCD, MAXP - 2, 16'h2BCD, 1'b0, 1'b0, "tog_edge");
      // R8 start while busy
      run_op(1'b0, 1'b0, 16'h3C3C, 8, 16'h3C3C, 1'b0, 1'b1, "busy_start_data");
      run_op(1'b1, 1'b0, 16'h6A6A, 8, 16'h6A6A, 1'b0, 1'b1, "busy_start_tog");

      for (int t = 0; t < 40; t++) begin
         bit            md, er, gb;
         logic [DW-1:0] ex, fn;
         int            nb;
         md = 1'($urandom);
         er = 1'($urandom);
         gb = 1'($urandom);
         ex = DW'($urandom);
         nb = $urandom % 15;
         fn = er ? '1 : ex;
         if ($urandom % 4 == 0) fn = fn ^ DW'(1 << ($urandom % DW));
         run_op(md, er, ex, nb, fn, gb, 1'b0, "random");
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule